// File: doc/BRIEF.md
# Round-Robin Iterative Matching Scheduler for an Input-Queued Switch

This block chooses which input of a 4x4 input-queued crossbar may send to which output in the next cell time. Every input keeps one queue per output, so it can ask for several outputs at the same time. A slot starts with a pulse on `start_i`. At that pulse the block captures the request matrix and the iteration budget. It then runs one request/grant/accept round per clock. Each round may add new input/output pairs to the match, and never removes a pair it has made.

Every output holds a grant pointer and every input holds an accept pointer. An output grants the first requesting, still unmatched input at or after its pointer in cyclic order. An input accepts the first granting output at or after its own pointer. Pointers move only when a grant is accepted, and only for pairs formed in the first round of a slot. Over busy slots this spreads the pointers apart, so the block settles into conflict-free service under heavy load.

When the last round finishes, `done_o` pulses for one cycle. The outputs then show, for each input, whether it was matched and which output it won. These values stay put until the next slot starts.

Top module: `islip_sched`

## Requirements
- R1: After reset, `done_o` is 0, `match_vld_o` is all zero, and every grant and accept pointer is 0.
- R2: In each round, every unmatched output grants the unmatched input that requests it and lies first in cyclic order starting at that output's grant pointer. Request bit `req_i[i*4+j]` means input i asks for output j.
- R3: Every unmatched input that got at least one grant accepts the granting output that lies first in cyclic order starting at its accept pointer.
- R4: For a pair (input i, output j) accepted in the first round of a slot, output j's grant pointer becomes (i+1) mod 4 and input i's accept pointer becomes (j+1) mod 4.
- R5: Grants that are not accepted, and pairs formed in the second or later rounds, leave all pointers unchanged.
- R6: The final match is one-to-one. No output is given to two inputs, and every pair is backed by a captured request. Ports matched in an earlier round take no part in later rounds.
- R7: `iters_i` (3 bits) sets the number of rounds K. A value of 0 means 1, and values above 4 mean 4. If `start_i` is sampled at clock edge E0, `done_o` is high for exactly the cycle that follows edge E0+K.
- R8: With K = 4, the final match is maximal: no unmatched input still requests an unmatched output.
- R9: A `start_i` pulse that arrives while a slot is running is ignored. Requests are captured only at an accepted start.
- R10: `done_o` lasts exactly one cycle. `match_vld_o` and `match_idx_o` (input i's output number in bits [2i+1:2i]) hold their values from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a scheduling slot when the block is idle |
| iters_i | input | 3 | Number of matching rounds for the slot |
| req_i | input | 16 | Request matrix; bit i*4+j set when input i has cells for output j |
| done_o | output | 1 | One-cycle pulse: final match valid |
| match_vld_o | output | 4 | Bit i set when input i is matched |
| match_idx_o | output | 8 | Output number won by input i, in bits [2i+1:2i] |

## Verification
The bench runs many back-to-back saturated slots. These tell the design apart from one that moves pointers on every grant or in every round: the spread of pointers across slots changes, so later matches differ from the reference model. A single input that asks for every output, and every input asking for one output, expose a wrong direction or wrong start in the cyclic search, because the winner would not rotate as expected. The budget values 0, 1 and 7 test the clamping. An off-by-one round count shows up as a `done_o` pulse a cycle early or late, or as a match that is not maximal. A second start during a running slot checks that a design which re-captures requests is caught, either through an extra done pulse or through a changed result.

// File: rtl/islip_pkg.sv
package islip_pkg;
    parameter int unsigned PORTS  = 4;
    parameter int unsigned ITER_W = 3;
endpackage

// File: rtl/islip_rr_pick.sv
// Cyclic priority pick: first set request at or after ptr.
module islip_rr_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  pick
);
    always_comb begin
        logic found;
        int   pos;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < int'(N); k++) begin
            pos = (int'(ptr) + k) % int'(N);
            if (!found && req[pos]) begin
                found     = 1'b1;
                pick[pos] = 1'b1;
            end
        end
    end

    always_comb begin
        AST_PICK_FROM_REQ: assert ((pick & ~req) == '0); // R2
        AST_PICK_SINGLE: assert ($onehot0(pick)); // R3
    end
endmodule

// File: rtl/islip_grant_stage.sv
// One cyclic picker per output; result gnt[j] is a one-hot input vector.
module islip_grant_stage #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0][N-1:0]  mreq,   // [input][output]
    input  logic [N-1:0][IW-1:0] gptr,   // per output
    output logic [N-1:0][N-1:0]  gnt     // [output][input]
);
    for (genvar j = 0; j < N; j++) begin : g_out
        logic [N-1:0] col;
        always_comb begin
            for (int i = 0; i < int'(N); i++) col[i] = mreq[i][j];
        end
        islip_rr_pick #(.N(N), .IW(IW)) u_pick (
            .req  (col),
            .ptr  (gptr[j]),
            .pick (gnt[j])
        );
    end
endmodule

// File: rtl/islip_accept_stage.sv
// One cyclic picker per input over the outputs that granted it.
module islip_accept_stage #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0][N-1:0]  gnt,     // [output][input]
    input  logic [N-1:0][IW-1:0] aptr,    // per input
    output logic [N-1:0]         acc_hit,
    output logic [N-1:0][IW-1:0] acc_idx
);
    logic [N-1:0][N-1:0] acc_oh;          // [input][output]

    for (genvar i = 0; i < N; i++) begin : g_in
        logic [N-1:0] row;
        always_comb begin
            for (int j = 0; j < int'(N); j++) row[j] = gnt[j][i];
        end
        islip_rr_pick #(.N(N), .IW(IW)) u_pick (
            .req  (row),
            .ptr  (aptr[i]),
            .pick (acc_oh[i])
        );
        always_comb begin
            acc_hit[i] = |acc_oh[i];
            acc_idx[i] = '0;
            for (int j = 0; j < int'(N); j++)
                if (acc_oh[i][j]) acc_idx[i] = IW'(j);
        end
    end

    // An output may be accepted by at most one input in a round.
    always_comb begin
        for (int j = 0; j < int'(N); j++) begin
            logic [N-1:0] takers;
            for (int i = 0; i < int'(N); i++) takers[i] = acc_oh[i][j];
            AST_OUT_SINGLE_ACCEPT: assert ($onehot0(takers)); // R6
        end
    end
endmodule

// File: rtl/islip_sched.sv
module islip_sched #(
    parameter int unsigned N      = islip_pkg::PORTS,
    parameter int unsigned ITER_W = islip_pkg::ITER_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ITER_W-1:0]    iters_i,
    input  logic [N*N-1:0]       req_i,
    output logic                 done_o,
    output logic [N-1:0]         match_vld_o,
    output logic [N*$clog2(N)-1:0] match_idx_o
);
    localparam int unsigned IW = $clog2(N);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic [IW-1:0]        iter;
        logic [IW-1:0]        last;
        logic [N-1:0][N-1:0]  req;    // [input][output]
        logic [N-1:0]         in_m;
        logic [N-1:0]         out_m;
        logic [N-1:0][IW-1:0] sel;
        logic [N-1:0][IW-1:0] gptr;
        logic [N-1:0][IW-1:0] aptr;
    } state_t;

    state_t st_q, st_d;

    logic [N-1:0][N-1:0]  mreq_d;
    logic [N-1:0][N-1:0]  gnt_d;
    logic [N-1:0]         acc_hit_d;
    logic [N-1:0][IW-1:0] acc_idx_d;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
        return (int'(v) == int'(N) - 1) ? '0 : IW'(int'(v) + 1);
    endfunction

    function automatic logic [IW-1:0] rounds_last(input logic [ITER_W-1:0] cfg);
        int eff;
        eff = int'(cfg);
        if (eff == 0)       eff = 1;
        if (eff > int'(N))  eff = int'(N);
        return IW'(eff - 1);
    endfunction

    // Requests still eligible this round
    always_comb begin
        for (int i = 0; i < int'(N); i++)
            for (int j = 0; j < int'(N); j++)
                mreq_d[i][j] = st_q.busy && st_q.req[i][j]
                               && !st_q.in_m[i] && !st_q.out_m[j];
    end

    islip_grant_stage #(.N(N), .IW(IW)) u_grant (
        .mreq (mreq_d),
        .gptr (st_q.gptr),
        .gnt  (gnt_d)
    );

    islip_accept_stage #(.N(N), .IW(IW)) u_accept (
        .gnt     (gnt_d),
        .aptr    (st_q.aptr),
        .acc_hit (acc_hit_d),
        .acc_idx (acc_idx_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.iter  = '0;
                st_d.last  = rounds_last(iters_i);
                st_d.in_m  = '0;
                st_d.out_m = '0;
                st_d.sel   = '0;
                for (int i = 0; i < int'(N); i++)
                    for (int j = 0; j < int'(N); j++)
                        st_d.req[i][j] = req_i[i*int'(N) + j];
            end
        end else begin
            for (int i = 0; i < int'(N); i++) begin
                if (acc_hit_d[i]) begin
                    st_d.in_m[i]             = 1'b1;
                    st_d.out_m[acc_idx_d[i]] = 1'b1;
                    st_d.sel[i]              = acc_idx_d[i];
                    if (st_q.iter == '0) begin
                        st_d.aptr[i]            = wrap_inc(acc_idx_d[i]);
                        st_d.gptr[acc_idx_d[i]] = wrap_inc(IW'(i));
                    end
                end
            end
            if (st_q.iter == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.iter = st_q.iter + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o      = st_q.done;
    assign match_vld_o = st_q.in_m;
    always_comb begin
        for (int i = 0; i < int'(N); i++)
            match_idx_o[i*int'(IW) +: IW] = st_q.sel[i];
    end

    // ---------------- checks on the registered result ----------------
    function automatic logic outs_distinct();
        for (int a = 0; a < int'(N); a++)
            for (int b = a + 1; b < int'(N); b++)
                if (match_vld_o[a] && match_vld_o[b] && st_q.sel[a] == st_q.sel[b])
                    return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic pairs_requested();
        for (int i = 0; i < int'(N); i++)
            if (match_vld_o[i] && !st_q.req[i][st_q.sel[i]]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic no_free_pair();
        logic [N-1:0] taken;
        taken = '0;
        for (int i = 0; i < int'(N); i++)
            if (match_vld_o[i]) taken[st_q.sel[i]] = 1'b1;
        for (int i = 0; i < int'(N); i++)
            for (int j = 0; j < int'(N); j++)
                if (!match_vld_o[i] && !taken[j] && st_q.req[i][j]) return 1'b0;
        return 1'b1;
    endfunction

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_MATCH_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> outs_distinct()); // R6
    AST_MATCH_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pairs_requested()); // R6
    AST_FULL_BUDGET_MAXIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && int'(st_q.last) == int'(N) - 1) |-> no_free_pair()); // R8
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.busy && st_q.iter == '0) |=> ($stable(st_q.gptr) && $stable(st_q.aptr))); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start_i) |=> ($stable(match_vld_o) && $stable(match_idx_o))); // R10
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> !done_o); // R9
endmodule

// File: tb/test_islip_sched.sv
`timescale 1ns/1ps
module test_islip_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  iters_i = '0;
    logic [15:0] req_i = '0;
    logic        done_o;
    logic [3:0]  match_vld_o;
    logic [7:0]  match_idx_o;

    always #2.5 clk = ~clk;

    islip_sched i_islip_sched (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .iters_i(iters_i),
        .req_i(req_i), .done_o(done_o), .match_vld_o(match_vld_o),
        .match_idx_o(match_idx_o)
    );

    typedef struct {
        logic [3:0] vld;
        logic [7:0] idx;
        int         due;
        string      tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0, n_bad = 0, cyc = 0;
    int mg[4], ma[4];
    logic [3:0] last_v;
    logic [7:0] last_x;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mask_idx(input logic [7:0] x, input logic [3:0] v);
        logic [7:0] r;
        for (int i = 0; i < 4; i++) r[i*2 +: 2] = v[i] ? x[i*2 +: 2] : 2'b00;
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference matcher from the requirements
    task automatic model(input logic [15:0] r, input int k,
                         output logic [3:0] v, output logic [7:0] x);
        logic [3:0] im, om;
        int g[4];
        v = '0; x = '0; im = '0; om = '0;
        for (int it = 0; it < k; it++) begin
            for (int j = 0; j < 4; j++) begin
                g[j] = -1;
                if (!om[j])
                    for (int s = 0; s < 4; s++) begin
                        int i = (mg[j] + s) % 4;
                        if (g[j] < 0 && !im[i] && r[i*4+j]) g[j] = i;
                    end
            end
            for (int i = 0; i < 4; i++) begin
                int a = -1;
                if (!im[i])
                    for (int s = 0; s < 4; s++) begin
                        int j = (ma[i] + s) % 4;
                        if (a < 0 && g[j] == i) a = j;
                    end
                if (a >= 0) begin
                    im[i] = 1'b1; om[a] = 1'b1; v[i] = 1'b1;
                    x[i*2 +: 2] = 2'(a);
                    if (it == 0) begin
                        ma[i] = (a + 1) % 4;
                        mg[a] = (i + 1) % 4;
                    end
                end
            end
        end
    endtask

    // Driver: predicts, pushes, drives one slot; optional start while busy
    task automatic run_slot(input logic [15:0] r, input logic [2:0] cfg,
                            input string tag, input bit poke);
        item_t it;
        int k;
        k = (cfg == 0) ? 1 : ((cfg > 4) ? 4 : int'(cfg));
        model(r, k, it.vld, it.idx);
        it.idx = mask_idx(it.idx, it.vld);
        it.tag = tag;
        @(negedge clk);
        it.due = cyc + 1 + k;
        sb.push_back(it);
        last_v = it.vld; last_x = it.idx;
        start_i = 1'b1; req_i = r; iters_i = cfg;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin                 // R9: ignored second start
            start_i = 1'b1; req_i = ~r; iters_i = 3'd1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);      // R10: result still held, no extra done
        check("R10 held valid", 32'(match_vld_o), 32'(last_v));
        check("R10 held index", 32'(mask_idx(match_idx_o, match_vld_o)), 32'(last_x));
    endtask

    // Monitor: pops on each done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R9/R10: actual done pulse, expected none");
            end else begin
                item_t e;
                e = sb.pop_front();
                check({e.tag, " valid"}, 32'(match_vld_o), 32'(e.vld));
                check({e.tag, " index"}, 32'(mask_idx(match_idx_o, match_vld_o)), 32'(e.idx));
                check("R7 done cycle", 32'(cyc), 32'(e.due));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mg[i] = 0; ma[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1 done after reset", 32'(done_o), 0);
        check("R1 valid after reset", 32'(match_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle no done", 32'(done_o), 0);

        // R1/R8: pointers start at 0, full load gives diagonal match
        run_slot(16'hFFFF, 3'd4, "R1/R8 first full slot", 0);
        // R4: repeated full load desynchronizes pointers
        for (int s = 0; s < 6; s++) run_slot(16'hFFFF, 3'd4, "R4 full load", 0);
        // R5/R7: single round, later rounds absent
        run_slot(16'hFFFF, 3'd1, "R5/R7 one round", 0);
        run_slot(16'hFFFF, 3'd0, "R7 zero budget", 0);
        run_slot(16'hFFFF, 3'd7, "R7 large budget", 0);
        run_slot(16'hFFFF, 3'd2, "R5 two rounds", 0);
        // R2: all inputs want output 2, winner rotates
        for (int s = 0; s < 5; s++) run_slot(16'h4444, 3'd4, "R2 one output", 0);
        // R3: input 1 wants everything, accepted output rotates
        for (int s = 0; s < 5; s++) run_slot(16'h00F0, 3'd4, "R3 one input", 0);
        // R6: overlapping partial patterns
        run_slot(16'h1248, 3'd3, "R6 anti diagonal", 0);
        run_slot(16'h0000, 3'd4, "R6 no requests", 0);
        // R9: start while busy is ignored
        run_slot(16'h8421, 3'd4, "R9 busy start", 1);
        run_slot(16'h3C3C, 3'd3, "R9 busy start", 1);
        // R8: random traffic with full budget; R6 with varied budget
        for (int s = 0; s < 40; s++)
            run_slot(16'($urandom), 3'd4, "R8 random", 0);
        for (int s = 0; s < 30; s++)
            run_slot(16'($urandom), 3'($urandom_range(0, 7)), "R6 random", 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule